// File: doc/BRIEF.md
# Pipeline Interlock and Branch Stall Unit

This block is the hazard controller of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) that has no operand forwarding. Each cycle it compares the two source register numbers of the instruction in decode with the destination registers of the instructions in execute and memory. If one of those will write a register that decode needs, the unit freezes the PC and the decode register and sends a bubble into execute. The hold lasts until the producer reaches writeback. The register file writes in the first half of the cycle and reads in the second, so decode can read a register in the same cycle that writeback writes it.

Control transfers are handled by an internal shadow of the pipeline. When a control-transfer instruction leaves decode, the unit records it and follows it through execute and memory. During that time it squashes every fetched slot and stops sequential PC advance. In the memory-stage cycle the datapath loads the target into the PC, so the unit drops the PC hold there. The next fetch therefore comes from the target. Sequential advance is never treated as a control hazard.

Top module: `hz_interlock`

## Requirements
- R1: When decode is valid and the execute-stage slot is valid, has its write enable set, and names a nonzero destination equal to decode's first source, `id_hold`, `pc_hold` and `bubble_ins` are all 1 in that same cycle.
- R2: A valid, writing memory-stage slot whose nonzero destination matches a decode source raises the same three outputs. A match in both later stages at once also stalls.
- R3: A producer that has left the memory stage never stalls decode. A load followed directly by a dependent instruction keeps that instruction in decode for exactly three cycles: two with `id_hold`=1 and the third with `id_hold`=0.
- R4: Register number 0 never causes a stall, either as a destination or as a source.
- R5: No stall occurs when decode is invalid, when the later slot is invalid, when its write enable is 0, or when no destination matches a source.
- R6: The second source is compared as well: a destination equal only to `id_rs2` stalls decode.
- R7: A valid control-transfer instruction (`id_ctl`=1) in decode with no data hazard is launched. In that same cycle `squash`=1, `pc_hold`=1 and `id_hold`=0.
- R8: In the cycle after launch, while the transfer is in execute, `squash`=1 and `pc_hold`=1.
- R9: In the second cycle after launch, while the transfer is in memory, `squash`=1 and `pc_hold`=0, so the PC takes the target. In the cycle after that, `squash` is 0 again.
- R10: A control-transfer instruction in decode that has a data hazard is not launched. During the hold, `id_hold`=1, `pc_hold`=1, `bubble_ins`=1 and `squash`=0. It is launched in the first cycle its hazard is gone.
- R11: While a transfer is in execute or memory, the decode slot is treated as squashed. It never raises `id_hold` or `bubble_ins`, and it cannot launch another transfer.
- R12: Synchronous active-high reset `rst` clears any transfer in flight. After reset, with idle inputs, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_ctl | input | 1 | Decode instruction changes the PC non-sequentially |
| id_rs1 | input | AW | Decode first source register |
| id_rs2 | input | AW | Decode second source register |
| ex_valid | input | 1 | Execute slot holds a real instruction |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_rd | input | AW | Execute destination register |
| mem_valid | input | 1 | Memory slot holds a real instruction |
| mem_we | input | 1 | Memory instruction writes a register |
| mem_rd | input | AW | Memory destination register |
| pc_hold | output | 1 | PC keeps its value this cycle |
| id_hold | output | 1 | Fetch/decode register keeps its contents |
| bubble_ins | output | 1 | Execute receives a bubble instead of decode's instruction |
| squash | output | 1 | Fetched slot entering decode is turned into a bubble |

## Verification
A data hazard and a control transfer can both hit the same decode slot. This happens when a branch needs a register that an instruction ahead of it is still producing. The bench sets this up by putting a control-transfer instruction in decode while a matching writer sits first in execute and then in memory. It expects two cycles of hold with bubbles and no squash. Once the writer has left, it expects the launch cycle, the execute cycle and the redirect cycle to follow in order. A second case overlaps the in-flight transfer with a decode slot that would otherwise stall, and checks that the squash wins and no hold is raised.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned NUM_LATE_SLOTS = 2;

  typedef enum logic [0:0] {
    SLOT_EX  = 1'b0,
    SLOT_MEM = 1'b1
  } late_slot_e;
endpackage

// File: rtl/hz_src_cmp.sv
module hz_src_cmp #(
  parameter int unsigned AW = 5
) (
  input  logic          src_live,
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] src_b,
  input  logic          slot_valid,
  input  logic          slot_we,
  input  logic [AW-1:0] slot_rd,
  output logic          hit
);
  logic writer;
  logic match_a;
  logic match_b;

  always_comb begin
    writer  = slot_valid && slot_we && (slot_rd != '0);
    match_a = (slot_rd == src_a);
    match_b = (slot_rd == src_b);
    hit     = src_live && writer && (match_a || match_b);
  end
endmodule

// File: rtl/hz_ctl_shadow.sv
module hz_ctl_shadow #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  output logic in_flight,
  output logic resolving
);
  logic [DEPTH-1:0] pos_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) pos_q <= '0;
        else     pos_q <= launch;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) pos_q <= '0;
        else     pos_q <= {pos_q[DEPTH-2:0], launch};
      end
    end
  endgenerate

  always_comb begin
    in_flight = |pos_q;
    resolving = pos_q[DEPTH-1];
  end
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock #(
  parameter int unsigned AW        = 5,
  parameter int unsigned CTL_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          id_valid,
  input  logic          id_ctl,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          ex_valid,
  input  logic          ex_we,
  input  logic [AW-1:0] ex_rd,
  input  logic          mem_valid,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_rd,
  output logic          pc_hold,
  output logic          id_hold,
  output logic          bubble_ins,
  output logic          squash
);
  import hz_pkg::*;

  localparam int unsigned NS = NUM_LATE_SLOTS;

  logic          slot_v  [NS];
  logic          slot_w  [NS];
  logic [AW-1:0] slot_rd [NS];
  logic [NS-1:0] slot_hit;

  logic in_flight;
  logic resolving;
  logic id_live;
  logic data_stall;
  logic launch;

  always_comb begin
    slot_v[SLOT_EX]   = ex_valid;
    slot_w[SLOT_EX]   = ex_we;
    slot_rd[SLOT_EX]  = ex_rd;
    slot_v[SLOT_MEM]  = mem_valid;
    slot_w[SLOT_MEM]  = mem_we;
    slot_rd[SLOT_MEM] = mem_rd;
  end

  // decode slot behind an unresolved transfer is a squashed slot
  assign id_live = id_valid && !in_flight;

  generate
    for (genvar s = 0; s < NS; s++) begin : g_cmp
      hz_src_cmp #(.AW(AW)) u_cmp (
        .src_live   (id_live),
        .src_a      (id_rs1),
        .src_b      (id_rs2),
        .slot_valid (slot_v[s]),
        .slot_we    (slot_w[s]),
        .slot_rd    (slot_rd[s]),
        .hit        (slot_hit[s])
      );
    end
  endgenerate

  assign data_stall = |slot_hit;
  assign launch     = id_live && id_ctl && !data_stall && !rst;

  hz_ctl_shadow #(.DEPTH(CTL_DEPTH)) u_shadow (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .in_flight (in_flight),
    .resolving (resolving)
  );

  always_comb begin
    id_hold    = data_stall;
    bubble_ins = data_stall;
    squash     = launch || in_flight;
    pc_hold    = data_stall || launch || (in_flight && !resolving);
  end
endmodule

// File: rtl/hz_interlock_chk.sv
module hz_interlock_chk #(
  parameter int unsigned AW        = 5,
  parameter int unsigned CTL_DEPTH = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          id_valid,
  input logic          id_ctl,
  input logic [AW-1:0] id_rs1,
  input logic [AW-1:0] id_rs2,
  input logic          ex_valid,
  input logic          ex_we,
  input logic [AW-1:0] ex_rd,
  input logic          mem_valid,
  input logic          mem_we,
  input logic [AW-1:0] mem_rd,
  input logic          pc_hold,
  input logic          id_hold,
  input logic          bubble_ins,
  input logic          squash
);
  p_hold_freezes_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    id_hold |-> (pc_hold && bubble_ins));

  p_zero_reg_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (id_rs1 == '0 && id_rs2 == '0) |-> !id_hold);

  p_idle_decode_r5: assert property (@(posedge clk) disable iff (rst)
    !id_valid |-> !id_hold);

  p_no_writers_r5: assert property (@(posedge clk) disable iff (rst)
    (!(ex_valid && ex_we) && !(mem_valid && mem_we)) |-> !id_hold);

  p_hold_excludes_squash_r10: assert property (@(posedge clk) disable iff (rst)
    id_hold |-> !squash);

  p_squash_not_during_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (squash && !(id_valid && id_ctl)) |-> !bubble_ins);

  generate
    if (CTL_DEPTH == 2) begin : g_seq
      p_launch_then_ex_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(squash) |=> (squash && pc_hold));

      p_redirect_at_mem_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(squash) |=> ##1 (squash && !pc_hold));
    end
  endgenerate
endmodule

bind hz_interlock hz_interlock_chk #(.AW(AW), .CTL_DEPTH(CTL_DEPTH)) u_chk (.*);

// File: tb/hz_interlock_tb.sv
module hz_interlock_tb;
  localparam int unsigned AW         = 5;
  localparam int          CLK_PERIOD = 10;
  localparam int          WDOG_LIMIT = 5000;
  localparam int          NVEC       = 10;

  typedef struct packed {
    logic          idv;
    logic [AW-1:0] rs1;
    logic [AW-1:0] rs2;
    logic          exv;
    logic          exw;
    logic [AW-1:0] exrd;
    logic          mv;
    logic          mw;
    logic [AW-1:0] mrd;
    logic          e_hold;
    logic          e_pch;
    logic          e_bub;
    logic          e_sq;
  } vec_t;

  // rows: decode(v,rs1,rs2) ex(v,we,rd) mem(v,we,rd) -> hold,pc_hold,bubble,squash
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 5'd8,  5'd3,  1'b1, 1'b1, 5'd8,  1'b0, 1'b0, 5'd0,  1'b1, 1'b1, 1'b1, 1'b0}, // R1
    '{1'b1, 5'd3,  5'd9,  1'b1, 1'b1, 5'd9,  1'b0, 1'b0, 5'd0,  1'b1, 1'b1, 1'b1, 1'b0}, // R6
    '{1'b1, 5'd4,  5'd6,  1'b0, 1'b0, 5'd0,  1'b1, 1'b1, 5'd4,  1'b1, 1'b1, 1'b1, 1'b0}, // R2
    '{1'b1, 5'd0,  5'd0,  1'b1, 1'b1, 5'd0,  1'b1, 1'b1, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0}, // R4
    '{1'b1, 5'd7,  5'd7,  1'b1, 1'b0, 5'd7,  1'b1, 1'b0, 5'd7,  1'b0, 1'b0, 1'b0, 1'b0}, // R5
    '{1'b1, 5'd7,  5'd2,  1'b0, 1'b1, 5'd7,  1'b0, 1'b1, 5'd2,  1'b0, 1'b0, 1'b0, 1'b0}, // R5
    '{1'b0, 5'd7,  5'd2,  1'b1, 1'b1, 5'd7,  1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0}, // R5
    '{1'b1, 5'd1,  5'd2,  1'b1, 1'b1, 5'd3,  1'b1, 1'b1, 5'd4,  1'b0, 1'b0, 1'b0, 1'b0}, // R5
    '{1'b1, 5'd10, 5'd11, 1'b1, 1'b1, 5'd11, 1'b1, 1'b1, 5'd10, 1'b1, 1'b1, 1'b1, 1'b0}, // R2
    '{1'b1, 5'd0,  5'd12, 1'b1, 1'b1, 5'd0,  1'b1, 1'b1, 5'd12, 1'b1, 1'b1, 1'b1, 1'b0}  // R4
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          id_valid, id_ctl;
  logic [AW-1:0] id_rs1, id_rs2;
  logic          ex_valid, ex_we;
  logic [AW-1:0] ex_rd;
  logic          mem_valid, mem_we;
  logic [AW-1:0] mem_rd;
  logic          pc_hold, id_hold, bubble_ins, squash;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hz_interlock #(.AW(AW), .CTL_DEPTH(2)) u_dut (
    .clk(clk), .rst(rst),
    .id_valid(id_valid), .id_ctl(id_ctl), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .ex_valid(ex_valid), .ex_we(ex_we), .ex_rd(ex_rd),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_rd(mem_rd),
    .pc_hold(pc_hold), .id_hold(id_hold), .bubble_ins(bubble_ins), .squash(squash)
  );

  function automatic string row_req(input int r);
    case (r)
      0:       return "R1";
      1:       return "R6";
      2, 8:    return "R2";
      3, 9:    return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check4(input string req, input logic e_hold, input logic e_pch,
                        input logic e_bub, input logic e_sq);
    checks++;
    if ({id_hold, pc_hold, bubble_ins, squash} !== {e_hold, e_pch, e_bub, e_sq}) begin
      errors++;
      $display("FAIL %s: hold/pc_hold/bubble/squash actual %b%b%b%b expected %b%b%b%b",
               req, id_hold, pc_hold, bubble_ins, squash, e_hold, e_pch, e_bub, e_sq);
    end
  endtask

  task automatic idle();
    id_valid = 0; id_ctl = 0; id_rs1 = '0; id_rs2 = '0;
    ex_valid = 0; ex_we = 0; ex_rd = '0;
    mem_valid = 0; mem_we = 0; mem_rd = '0;
  endtask

  task automatic next_cycle();
    @(negedge clk);
  endtask

  task automatic settle();
    #(CLK_PERIOD/4);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WDOG_LIMIT) begin
        checks++;
        errors++;
        $display("FAIL watchdog: cycles actual %0d expected below %0d", cycles, WDOG_LIMIT);
        finish_run();
      end
    end
  end

  initial begin
    idle();
    rst = 1;
    // reset with a transfer request pending must not leave anything in flight
    id_valid = 1; id_ctl = 1;
    next_cycle(); next_cycle();
    idle();
    rst = 0;
    settle();
    check4("R12 reset state", 0, 0, 0, 0);

    // table walk: pure data hazards
    for (int r = 0; r < NVEC; r++) begin
      next_cycle();
      id_valid = VECS[r].idv; id_ctl = 0;
      id_rs1 = VECS[r].rs1; id_rs2 = VECS[r].rs2;
      ex_valid = VECS[r].exv; ex_we = VECS[r].exw; ex_rd = VECS[r].exrd;
      mem_valid = VECS[r].mv; mem_we = VECS[r].mw; mem_rd = VECS[r].mrd;
      settle();
      check4(row_req(r), VECS[r].e_hold, VECS[r].e_pch, VECS[r].e_bub, VECS[r].e_sq);
    end

    // R3: load to r8, dependent add reads r8; count cycles in decode
    next_cycle(); idle();
    id_valid = 1; id_rs1 = 5'd8; id_rs2 = 5'd1;
    ex_valid = 1; ex_we = 1; ex_rd = 5'd8;
    settle();
    check4("R3 load in execute", 1, 1, 1, 0);
    next_cycle();
    ex_valid = 0; ex_we = 0; ex_rd = '0;
    mem_valid = 1; mem_we = 1; mem_rd = 5'd8;
    settle();
    check4("R3 load in memory", 1, 1, 1, 0);
    next_cycle();
    mem_valid = 0; mem_we = 0; mem_rd = '0;
    settle();
    check4("R3 load in writeback, add leaves decode on third cycle", 0, 0, 0, 0);

    // R7-R9: transfer followed by two fetched slots, then target
    next_cycle(); idle();
    id_valid = 1; id_ctl = 1;
    settle();
    check4("R7 launch cycle", 0, 1, 0, 1);
    next_cycle(); idle();
    // R11: squashed slot that would otherwise stall and launch
    id_valid = 1; id_ctl = 1; id_rs1 = 5'd6;
    ex_valid = 1; ex_we = 1; ex_rd = 5'd6;
    settle();
    check4("R8/R11 transfer in execute, first wrong fetch squashed", 0, 1, 0, 1);
    next_cycle(); idle();
    id_valid = 1;
    settle();
    check4("R9 transfer in memory, second wrong fetch squashed, PC redirect", 0, 0, 0, 1);
    next_cycle(); idle();
    id_valid = 1;
    settle();
    check4("R9/R11 target fetch proceeds, no relaunch", 0, 0, 0, 0);

    // R10: transfer waiting on r5 with its writer ahead
    next_cycle(); idle();
    id_valid = 1; id_ctl = 1; id_rs1 = 5'd5;
    ex_valid = 1; ex_we = 1; ex_rd = 5'd5;
    settle();
    check4("R10 transfer held, writer in execute", 1, 1, 1, 0);
    next_cycle();
    ex_valid = 0; ex_we = 0; ex_rd = '0;
    mem_valid = 1; mem_we = 1; mem_rd = 5'd5;
    settle();
    check4("R10 transfer held, writer in memory", 1, 1, 1, 0);
    next_cycle();
    mem_valid = 0; mem_we = 0; mem_rd = '0;
    settle();
    check4("R10 transfer launches once clear", 0, 1, 0, 1);
    next_cycle(); idle();
    settle();
    check4("R10 after launch, execute cycle", 0, 1, 0, 1);
    next_cycle();
    settle();
    check4("R10 after launch, redirect cycle", 0, 0, 0, 1);

    // R12: reset during flight
    next_cycle(); idle();
    id_valid = 1; id_ctl = 1;
    settle();
    check4("R12 launch before reset", 0, 1, 0, 1);
    next_cycle(); idle();
    rst = 1;
    next_cycle();
    rst = 0;
    settle();
    check4("R12 shadow cleared by reset", 0, 0, 0, 0);

    finish_run();
  end
endmodule